// File: doc/BRIEF.md
# Multiword Multiply-Accumulate Unit

This block is an unsigned multi-precision multiply-accumulate engine that keeps its own state. It holds three 64-bit multiplicand limbs and three 64-bit carry words. Each command is a start strobe with a function code and two 64-bit operands. Load commands fill a multiplicand limb or a carry word. Arithmetic commands multiply the stored multiplicand by operand A and add operand B and the stored carry words. The low 64-bit word of the sum comes out on the result port. The upper words go back into the carry registers, so the next command continues the same wide computation.

A sequence of triple-limb steps multiplies a 192-bit number by a number of any length, one 64-bit word at a time. Further steps with zero operands then drain the carry words. The unit has a single 64x64 multiplier, and an arithmetic command uses it once for each multiplicand limb it involves.

Top module: `mwmac_unit`

## Requirements
- R1: After reset the result output is zero, done is low, and every multiplicand limb and carry word is zero.
- R2: Function codes 0x08, 0x0c and 0x0d write operand A into multiplicand limbs 0, 1 and 2. Each of these writes also clears all three carry words.
- R3: Function codes 0x09, 0x0a and 0x0b write operand A into carry words 0, 1 and 2. Nothing else changes.
- R4: Function code 0x0f forms the 128-bit sum limb0*A + B + carry0. It returns bits 63:0 and writes bits 127:64 into carry word 0. Carry words 1 and 2 stay as they are.
- R5: Function code 0x11 forms the 256-bit sum {limb2,limb1,limb0}*A + B + {carry2,carry1,carry0}, with exact unsigned carries between words. It returns word 0 and writes words 1, 2 and 3 into carry words 0, 1 and 2.
- R6: Function code 0x10 forms limb0*A + B + carry0 truncated to 64 bits. It returns that value, writes it into multiplicand limb 0, and clears all three carry words.
- R7: done_o is a one-cycle pulse. It comes 1 cycle after an accepted load or unknown command, 2 cycles after 0x0f or 0x10, and 4 cycles after 0x11. The state registers take their new values in the cycle done rises.
- R8: A start that arrives while an arithmetic command is in progress is ignored and changes no state.
- R9: Any other function code gives a done pulse after 1 cycle and changes no state and no result.
- R10: result_o keeps its value between done pulses. Load commands do not change it.
- R11: Loading a 192-bit multiplicand, issuing 0x11 once per 64-bit word of a 128-bit multiplier with B zero, and then three 0x11 steps with zero operands returns the 320-bit product, least significant word first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, sampled when the unit is idle |
| op_i | input | 6 | Function code |
| opa_i | input | 64 | Operand A: the multiplier word, or the value written by a load |
| opb_i | input | 64 | Operand B: the addend |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Low word of the last arithmetic result |

## Verification
The hardest state to reach from the ports is a start that arrives while a multi-cycle step is running. This includes a start in the very cycle the step commits. Such a start must not disturb the step or the registers it is about to write. The stimulus issues loads of every kind on each busy cycle of a triple-limb step. It also keeps the strobe toggling on idle and busy cycles during a long run of random commands. The carry registers cannot be read directly. So zero-operand triple-limb steps shift them out through the result port, and carry chains with all-ones operands exercise every word boundary.

// File: rtl/mwmac_pkg.sv
package mwmac_pkg;
  localparam int unsigned MW_LIMBS = 3;
  localparam int unsigned MW_SELW  = $clog2(MW_LIMBS);
  localparam int unsigned MW_FNW   = 6;

  typedef enum logic [MW_FNW-1:0] {
    FN_LD_M0 = 6'h08,
    FN_LD_P0 = 6'h09,
    FN_LD_P1 = 6'h0a,
    FN_LD_P2 = 6'h0b,
    FN_LD_M1 = 6'h0c,
    FN_LD_M2 = 6'h0d,
    FN_MAC1  = 6'h0f,
    FN_FOLD  = 6'h10,
    FN_MAC3  = 6'h11
  } mw_fn_e;

  typedef struct packed {
    logic               wr_mpl;
    logic               wr_p;
    logic [MW_SELW-1:0] sel;
    logic               mul;
    logic               fold;
    logic               wide;
    logic [MW_SELW-1:0] last;
  } mw_ctrl_t;
endpackage

// File: rtl/mwmac_decode.sv
module mwmac_decode
  import mwmac_pkg::*;
(
  input  logic [MW_FNW-1:0] fn_i,
  output mw_ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (fn_i)
      FN_LD_M0: begin ctrl_o.wr_mpl = 1'b1; ctrl_o.sel = MW_SELW'(0); end
      FN_LD_M1: begin ctrl_o.wr_mpl = 1'b1; ctrl_o.sel = MW_SELW'(1); end
      FN_LD_M2: begin ctrl_o.wr_mpl = 1'b1; ctrl_o.sel = MW_SELW'(2); end
      FN_LD_P0: begin ctrl_o.wr_p   = 1'b1; ctrl_o.sel = MW_SELW'(0); end
      FN_LD_P1: begin ctrl_o.wr_p   = 1'b1; ctrl_o.sel = MW_SELW'(1); end
      FN_LD_P2: begin ctrl_o.wr_p   = 1'b1; ctrl_o.sel = MW_SELW'(2); end
      FN_MAC1:  begin ctrl_o.mul = 1'b1; ctrl_o.last = '0; end
      FN_FOLD:  begin ctrl_o.mul = 1'b1; ctrl_o.fold = 1'b1; ctrl_o.last = '0; end
      FN_MAC3:  begin
        ctrl_o.mul  = 1'b1;
        ctrl_o.wide = 1'b1;
        ctrl_o.last = MW_SELW'(MW_LIMBS - 1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mwmac_regs.sv
module mwmac_regs
  import mwmac_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_mpl_i,
  input  logic                     wr_p_i,
  input  logic [MW_SELW-1:0]       sel_i,
  input  logic [XLEN-1:0]          wdata_i,
  input  logic                     fold_i,
  input  logic [XLEN-1:0]          fold_val_i,
  input  logic [MW_LIMBS-1:0]      upd_en_i,
  input  logic [MW_LIMBS*XLEN-1:0] upd_val_i,
  output logic [MW_LIMBS*XLEN-1:0] mpl_o,
  output logic [MW_LIMBS*XLEN-1:0] p_o
);
  for (genvar k = 0; k < MW_LIMBS; k++) begin : g_limb
    logic [XLEN-1:0] mpl_q, p_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mpl_q <= '0;
      end else if (wr_mpl_i && sel_i == MW_SELW'(k)) begin
        mpl_q <= wdata_i;
      end else if (fold_i && (k == 0)) begin
        mpl_q <= fold_val_i;
      end
    end

    // any multiplicand write or fold restarts the carry chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q <= '0;
      end else if (wr_mpl_i || fold_i) begin
        p_q <= '0;
      end else if (wr_p_i && sel_i == MW_SELW'(k)) begin
        p_q <= wdata_i;
      end else if (upd_en_i[k]) begin
        p_q <= upd_val_i[k*XLEN +: XLEN];
      end
    end

    assign mpl_o[k*XLEN +: XLEN] = mpl_q;
    assign p_o[k*XLEN +: XLEN]   = p_q;
  end
endmodule

// File: rtl/mwmac_mulacc.sv
module mwmac_mulacc
  import mwmac_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN*(MW_LIMBS+1)-1:0] acc_i,
  input  logic [MW_LIMBS*XLEN-1:0]     mpl_i,
  input  logic [XLEN-1:0]              a_i,
  input  logic [MW_SELW-1:0]           sel_i,
  output logic [XLEN*(MW_LIMBS+1)-1:0] acc_o
);
  localparam int unsigned ACCW = XLEN * (MW_LIMBS + 1);
  localparam int unsigned PRW  = 2 * XLEN;

  logic [XLEN-1:0] mcand;
  logic [PRW-1:0]  prod;
  logic [ACCW-1:0] addend;

  always_comb begin
    mcand = '0;
    for (int k = 0; k < MW_LIMBS; k++) begin
      if (sel_i == MW_SELW'(k)) mcand = mpl_i[k*XLEN +: XLEN];
    end
  end

  assign prod = PRW'(mcand) * PRW'(a_i);

  // align the partial product to the weight of the selected limb
  always_comb begin
    addend = '0;
    for (int k = 0; k < MW_LIMBS; k++) begin
      if (sel_i == MW_SELW'(k)) addend[k*XLEN +: PRW] = prod;
    end
  end

  assign acc_o = acc_i + addend;
endmodule

// File: rtl/mwmac_unit.sv
module mwmac_unit
  import mwmac_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MW_FNW-1:0] op_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              done_o,
  output logic [XLEN-1:0]   result_o
);
  localparam int unsigned ACCW = XLEN * (MW_LIMBS + 1);
  localparam int unsigned PW   = XLEN * MW_LIMBS;

  mw_ctrl_t           ctrl;
  logic               busy_q, fold_q, wide_q, done_q;
  logic [MW_SELW-1:0] cnt_q, last_q;
  logic [XLEN-1:0]    a_q, result_q;
  logic [ACCW-1:0]    acc_q, acc_nx, acc_init;
  logic [PW-1:0]      mpl_flat, p_flat, upd_val;
  logic [MW_LIMBS-1:0] upd_en;
  logic               accept, finish;

  mwmac_decode i_decode (
    .fn_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign accept = start_i && !busy_q;
  assign finish = busy_q && (cnt_q == last_q);

  // wide steps take every carry word, the others only the lowest
  always_comb begin
    acc_init = ACCW'(opb_i);
    if (ctrl.wide) acc_init = acc_init + ACCW'(p_flat);
    else           acc_init = acc_init + ACCW'(p_flat[XLEN-1:0]);
  end

  mwmac_mulacc #(.XLEN(XLEN)) i_mulacc (
    .acc_i (acc_q),
    .mpl_i (mpl_flat),
    .a_i   (a_q),
    .sel_i (cnt_q),
    .acc_o (acc_nx)
  );

  for (genvar k = 0; k < MW_LIMBS; k++) begin : g_upd
    assign upd_val[k*XLEN +: XLEN] = acc_nx[(k+1)*XLEN +: XLEN];
    assign upd_en[k] = finish && !fold_q && (wide_q || (k == 0));
  end

  mwmac_regs #(.XLEN(XLEN)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_mpl_i   (accept && ctrl.wr_mpl),
    .wr_p_i     (accept && ctrl.wr_p),
    .sel_i      (ctrl.sel),
    .wdata_i    (opa_i),
    .fold_i     (finish && fold_q),
    .fold_val_i (acc_nx[XLEN-1:0]),
    .upd_en_i   (upd_en),
    .upd_val_i  (upd_val),
    .mpl_o      (mpl_flat),
    .p_o        (p_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      fold_q   <= 1'b0;
      wide_q   <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      a_q      <= '0;
      acc_q    <= '0;
      result_q <= '0;
    end else if (accept && ctrl.mul) begin
      busy_q <= 1'b1;
      fold_q <= ctrl.fold;
      wide_q <= ctrl.wide;
      cnt_q  <= '0;
      last_q <= ctrl.last;
      a_q    <= opa_i;
      acc_q  <= acc_init;
    end else if (busy_q) begin
      acc_q <= acc_nx;
      cnt_q <= cnt_q + MW_SELW'(1);
      if (finish) begin
        busy_q   <= 1'b0;
        result_q <= acc_nx[XLEN-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= (accept && !ctrl.mul) || finish;
  end

  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/mwmac_unit_chk.sv
module mwmac_unit_chk
  import mwmac_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic [MW_FNW-1:0]        op_i,
  input logic                     busy_i,
  input logic                     done_i,
  input logic [XLEN-1:0]          result_i,
  input logic [MW_LIMBS*XLEN-1:0] mpl_i,
  input logic [MW_LIMBS*XLEN-1:0] p_i
);
  logic idle_start;
  assign idle_start = start_i && !busy_i;

  assert_mload_clears_p_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_start && (op_i == FN_LD_M0 || op_i == FN_LD_M1 || op_i == FN_LD_M2)) |=> (p_i == '0));

  assert_pload_keeps_mpl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_start && (op_i == FN_LD_P0 || op_i == FN_LD_P1 || op_i == FN_LD_P2)) |=> $stable(mpl_i));

  assert_done_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_mac1_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_start && op_i == FN_MAC1) |=> (busy_i && !done_i) ##1 (done_i && !busy_i));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_i) |-> done_i);
endmodule

bind mwmac_unit mwmac_unit_chk #(.XLEN(XLEN)) i_mwmac_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .busy_i   (busy_q),
  .done_i   (done_o),
  .result_i (result_o),
  .mpl_i    (mpl_flat),
  .p_i      (p_flat)
);

// File: tb/test_mwmac_unit.sv
`timescale 1ns/1ps
module test_mwmac_unit;
  import mwmac_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  op = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        done;
  logic [63:0] result;

  always #2.5 clk = ~clk;

  mwmac_unit i_mwmac_unit (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .op_i     (op),
    .opa_i    (opa),
    .opb_i    (opb),
    .done_o   (done),
    .result_o (result)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [63:0] m_mpl [3];
  logic [63:0] m_p   [3];
  int          left = 0;
  logic [5:0]  pend_op;
  logic [63:0] pend_a, pend_b;
  logic        exp_done = 1'b0;
  logic [63:0] exp_res = '0;
  string       res_tag = "R1";

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic void finish_op();
    logic [255:0] s;
    case (pend_op)
      FN_MAC3: begin
        s = {64'b0, m_mpl[2], m_mpl[1], m_mpl[0]} * 256'(pend_a) + 256'(pend_b)
            + {64'b0, m_p[2], m_p[1], m_p[0]};
        exp_res = s[63:0];
        m_p[0] = s[127:64]; m_p[1] = s[191:128]; m_p[2] = s[255:192];
        res_tag = "R5";
      end
      FN_FOLD: begin
        s = 256'(m_mpl[0]) * 256'(pend_a) + 256'(pend_b) + 256'(m_p[0]);
        exp_res = s[63:0];
        m_mpl[0] = s[63:0];
        m_p[0] = '0; m_p[1] = '0; m_p[2] = '0;
        res_tag = "R6";
      end
      default: begin
        s = 256'(m_mpl[0]) * 256'(pend_a) + 256'(pend_b) + 256'(m_p[0]);
        exp_res = s[63:0];
        m_p[0] = s[127:64];
        res_tag = "R4";
      end
    endcase
  endfunction

  function automatic void model_edge(input bit s, input logic [5:0] f, input logic [63:0] a, input logic [63:0] b);
    exp_done = 1'b0;
    if (left > 0) begin
      left--;                       // R8: start ignored while busy
      if (left == 0) begin
        finish_op();
        exp_done = 1'b1;
      end
    end else if (s) begin
      exp_done = 1'b1;
      case (f)
        FN_LD_M0, FN_LD_M1, FN_LD_M2: begin
          m_mpl[f == FN_LD_M0 ? 0 : (f == FN_LD_M1 ? 1 : 2)] = a;
          m_p[0] = '0; m_p[1] = '0; m_p[2] = '0;
          res_tag = "R2";
        end
        FN_LD_P0: begin m_p[0] = a; res_tag = "R3"; end
        FN_LD_P1: begin m_p[1] = a; res_tag = "R3"; end
        FN_LD_P2: begin m_p[2] = a; res_tag = "R3"; end
        FN_MAC1, FN_FOLD: begin left = 1; exp_done = 1'b0; end
        FN_MAC3:          begin left = 3; exp_done = 1'b0; end
        default: res_tag = "R9";
      endcase
      pend_op = f; pend_a = a; pend_b = b;
    end
  endfunction

  task automatic step(input bit s, input logic [5:0] f, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    check(done === exp_done, "R7", 64'(done), 64'(exp_done));
    check(result === exp_res, exp_done ? res_tag : (res_tag == "R1" ? "R1" : "R10"), result, exp_res);
    start = s; op = f; opa = a; opb = b;
    model_edge(s, f, a, b);
  endtask

  task automatic run(input logic [5:0] f, input logic [63:0] a, input logic [63:0] b);
    step(1'b1, f, a, b);
    repeat (5) step(1'b0, '0, '0, '0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  localparam logic [63:0] ONES = '1;

  initial begin
    for (int k = 0; k < 3; k++) begin m_mpl[k] = '0; m_p[k] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset values; zero multiplicand and carry leave only B
    run(FN_MAC1, 64'd5, 64'd7);
    check(result === 64'd7, "R1", result, 64'd7);

    // R2, R4: carry into the high word with all-ones operands
    run(FN_LD_M0, ONES, '0);
    run(FN_LD_P0, ONES, '0);
    run(FN_MAC1, ONES, ONES);
    run(FN_MAC1, 64'd0, 64'd0);     // R4: drained carry word 0

    // R3, R2: carry loads, then a multiplicand load wipes them
    run(FN_LD_P1, 64'h1111, '0);
    run(FN_LD_P2, 64'h2222, '0);
    run(FN_LD_M1, 64'h3, '0);
    run(FN_MAC3, 64'd0, 64'd0);
    // R3: carry loads survive; zero-operand wide steps shift them out
    run(FN_LD_M0, '0, '0); run(FN_LD_M1, '0, '0); run(FN_LD_M2, '0, '0);
    run(FN_LD_P0, 64'hA0, '0); run(FN_LD_P1, 64'hB1, '0); run(FN_LD_P2, 64'hC2, '0);
    repeat (4) run(FN_MAC3, '0, '0);

    // R5: every carry boundary at once
    run(FN_LD_M0, ONES, '0); run(FN_LD_M1, ONES, '0); run(FN_LD_M2, ONES, '0);
    run(FN_LD_P0, ONES, '0); run(FN_LD_P1, ONES, '0); run(FN_LD_P2, ONES, '0);
    run(FN_MAC3, ONES, ONES);
    repeat (3) run(FN_MAC3, '0, '0);

    // R6: fold result becomes the new multiplicand limb 0
    run(FN_LD_M0, 64'h1234_5678_9abc_def1, '0);
    run(FN_LD_P0, 64'hffff_0000_ffff_0000, '0);
    run(FN_FOLD, 64'hdead_beef_0bad_f00d, 64'h55);
    run(FN_MAC1, 64'd1, 64'd0);

    // R8: loads of every kind during each busy cycle of a wide step
    step(1'b1, FN_MAC3, 64'h77, 64'h9);
    step(1'b1, FN_LD_M0, 64'hAAAA, '0);
    step(1'b1, FN_LD_P0, 64'hBBBB, '0);
    step(1'b1, FN_LD_M2, 64'hCCCC, '0);
    step(1'b1, FN_LD_P1, 64'h1, '0);   // accepted right after done
    repeat (4) step(1'b0, '0, '0, '0);
    run(FN_MAC3, 64'd3, 64'd0);

    // R9: unknown codes
    run(6'h00, ONES, ONES);
    run(6'h3f, ONES, ONES);
    run(6'h0e, ONES, ONES);
    run(FN_MAC1, 64'd2, 64'd0);

    // R7, R10: back-to-back loads with start held
    step(1'b1, FN_LD_M0, 64'h10, '0);
    step(1'b1, FN_LD_P0, 64'h20, '0);
    step(1'b1, FN_MAC1, 64'h30, 64'h1);
    step(1'b1, FN_MAC1, 64'h40, 64'h2);
    repeat (5) step(1'b0, '0, '0, '0);

    // random commands, strobe also toggling during busy cycles
    for (int i = 0; i < 500; i++) begin
      logic [5:0] codes [10];
      codes = '{FN_LD_M0, FN_LD_M1, FN_LD_M2, FN_LD_P0, FN_LD_P1, FN_LD_P2,
                FN_MAC1, FN_FOLD, FN_MAC3, 6'h15};
      step(1'b1, codes[$urandom_range(0, 9)], rnd64(), rnd64());
      for (int g = 0; g < int'($urandom_range(0, 3)); g++)
        step(1'(($urandom_range(0, 1))), codes[$urandom_range(0, 9)], rnd64(), rnd64());
    end
    repeat (5) step(1'b0, '0, '0, '0);

    // R11: 192x128 product built from chained wide steps
    for (int t = 0; t < 3; t++) begin
      logic [191:0] x;
      logic [127:0] y;
      logic [319:0] got, want;
      x = (t == 0) ? '1 : {rnd64(), rnd64(), rnd64()};
      y = (t == 0) ? '1 : {rnd64(), rnd64()};
      run(FN_LD_M0, x[63:0], '0);
      run(FN_LD_M1, x[127:64], '0);
      run(FN_LD_M2, x[191:128], '0);
      run(FN_MAC3, y[63:0], '0);    got[63:0]    = result;
      run(FN_MAC3, y[127:64], '0);  got[127:64]  = result;
      run(FN_MAC3, '0, '0);         got[191:128] = result;
      run(FN_MAC3, '0, '0);         got[255:192] = result;
      run(FN_MAC3, '0, '0);         got[319:256] = result;
      want = 320'(x) * 320'(y);
      n_chk++;
      if (got !== want) begin
        n_bad++;
        $display("FAIL R11 actual=%h expected=%h", got, want);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule